// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day value for packet timestamping. Time is held as a 64-bit count of whole nanoseconds together with a 32-bit binary fraction of a nanosecond. On every core clock cycle in which counting is enabled, a programmable per-cycle step is added. The step has 32 whole-nanosecond bits and 32 fraction bits. Software trims the clock frequency by changing this step, and never touches the clock itself. For a core clock of frequency f, the nominal step is (10^9 * 2^32) / f. At 1 GHz that is 0x1_0000_0000, and at 50 MHz it is 0x14_0000_0000.

Software controls the block through a simple synchronous register bus with 64-bit accesses. A write strobe takes effect on the clock edge where it is sampled. A read strobe returns registered data, with a valid flag, one cycle later. Software can set the time by loading the whole-nanosecond field or the fraction field. Neither load disturbs the programmed step.

Top module: `ptp_tod_counter`

## Requirements
- R1: After synchronous reset, the control register, the fraction, the nanosecond count and the step register all read back as zero.
- R2: In each enabled cycle, the fraction becomes (fraction + step[31:0]) mod 2^32. The nanosecond count gains step[63:32] plus the carry out of that fraction sum, in the same cycle.
- R3: Bit 0 of the control register enables counting. While bit 0 is clear, the nanosecond count and the fraction hold their values.
- R4: Bits 63:1 of the control register are stored as written and read back unchanged. They do not affect counting.
- R5: Register offsets are as follows. 0xF00 is control. 0xF08 is the fraction, held in bits 31:0, with bits 63:32 reading as zero. 0xF10 is the nanosecond count. 0xF18 is the step. A read of any other offset returns zero, and a write to any other offset changes no state.
- R6: The nanosecond count wraps modulo 2^64.
- R7: A write to the nanosecond register loads all 64 bits and clears the fraction. This takes precedence over counting in that cycle.
- R8: A write to the fraction register loads the fraction from bits 31:0, overriding counting for the fraction. The nanosecond field still advances in that cycle if counting is enabled, using the carry from the old fraction.
- R9: A write to the step register does not alter the accumulated time. The new step is first added on the clock edge after the write edge. A write to the control register also changes counting from the next edge onward.
- R10: A read strobe sampled on a clock edge makes `rd_valid` high for exactly the next cycle. `rd_data` then carries the register value as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a read result |

## Verification
A wrong accumulator state, such as a dropped fraction carry, a step applied one edge early, or a load that fails to clear the fraction, appears only in what a read returns. The reference model therefore shadows every cycle. The bench issues frequent reads of the fraction and nanosecond registers, and each response is compared one cycle after the read strobe. Most faults corrupt the time within a few cycles of the stimulus. Carry faults need a step whose fraction overflows, so some steps are chosen to overflow every second cycle. A wrong read path or valid flag is visible on the very next cycle after any read.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int unsigned OFS_CTRL = 32'hF00;
  localparam int unsigned OFS_FRAC = 32'hF08;
  localparam int unsigned OFS_NSEC = 32'hF10;
  localparam int unsigned OFS_STEP = 32'hF18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_FRAC,
    SEL_NSEC,
    SEL_STEP
  } reg_sel_e;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NS_W-1:0]   cur_ns,
  input  logic [FRAC_W-1:0] cur_frac,
  output logic              count_en,
  output logic [STEP_W-1:0] step,
  output logic              load_ns,
  output logic              load_frac,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  reg_sel_e            sel;
  logic [DATA_W-1:0]   ctrl_q;
  logic [STEP_W-1:0]   step_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rd_data_q;
  logic                rd_valid_q;

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_FRAC)) sel = SEL_FRAC;
    else if (bus_addr == ADDR_W'(OFS_NSEC)) sel = SEL_NSEC;
    else if (bus_addr == ADDR_W'(OFS_STEP)) sel = SEL_STEP;
    else                                    sel = SEL_NONE;
  end

  assign load_ns   = bus_wr && (sel == SEL_NSEC);
  assign load_frac = bus_wr && (sel == SEL_FRAC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      step_q <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_CTRL) ctrl_q <= bus_wdata;
      if (sel == SEL_STEP) step_q <= STEP_W'(bus_wdata);
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_FRAC: rd_mux = DATA_W'(cur_frac);
      SEL_NSEC: rd_mux = DATA_W'(cur_ns);
      SEL_STEP: rd_mux = DATA_W'(step_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= bus_rd;
      rd_data_q  <= bus_rd ? rd_mux : '0;
    end
  end

  assign count_en = ctrl_q[0];
  assign step     = step_q;
  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R10: one-cycle valid pulse follows each read strobe
  a_r10_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rd_valid);
  // R5: unmapped offsets read as zero
  a_r5_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> (rd_data == '0));
  // R9: a step write leaves the control register untouched
  a_r9_step_write_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_STEP) |=> $stable(ctrl_q));
endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum #(
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_en,
  input  logic [STEP_W-1:0] step,
  input  logic              load_ns,
  input  logic              load_frac,
  input  logic [DATA_W-1:0] wdata,
  output logic [NS_W-1:0]   ns,
  output logic [FRAC_W-1:0] frac
);
  localparam int INT_W = STEP_W - FRAC_W;

  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;
  logic              frac_carry;
  logic [INT_W-1:0]  step_int;
  logic [NS_W-1:0]   ns_adv;

  assign step_int   = step[STEP_W-1:FRAC_W];
  assign frac_sum   = {1'b0, frac_q} + {1'b0, step[FRAC_W-1:0]};
  assign frac_carry = frac_sum[FRAC_W];
  assign ns_adv     = ns_q + NS_W'(step_int) + NS_W'(frac_carry);

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_ns) begin
      ns_q   <= NS_W'(wdata);
      frac_q <= '0;
    end else if (load_frac) begin
      frac_q <= wdata[FRAC_W-1:0];
      if (count_en) ns_q <= ns_adv;
    end else if (count_en) begin
      ns_q   <= ns_adv;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  assign ns   = ns_q;
  assign frac = frac_q;

  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    // R1: time is zero on the edge after a reset cycle
    if (rst_d === 1'b1)
      a_r1_reset_clears_time: assert (ns_q == '0 && frac_q == '0);
  end

  // R3: disabled and not loaded means time holds
  a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !load_ns && !load_frac) |=> ($stable(ns_q) && $stable(frac_q)));
  // R7: nanosecond load wins and clears the fraction
  a_r7_ns_load_clears_frac: assert property (@(posedge clk) disable iff (rst)
    load_ns |=> (ns_q == NS_W'($past(wdata)) && frac_q == '0));
  // R8: fraction load wins over counting for the fraction
  a_r8_frac_load: assert property (@(posedge clk) disable iff (rst)
    (load_frac && !load_ns) |=> (frac_q == $past(wdata[FRAC_W-1:0])));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              count_en;
  logic [STEP_W-1:0] step;
  logic              load_ns;
  logic              load_frac;
  logic [NS_W-1:0]   cur_ns;
  logic [FRAC_W-1:0] cur_frac;

  ptp_tod_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cur_ns(cur_ns), .cur_frac(cur_frac),
    .count_en(count_en), .step(step), .load_ns(load_ns), .load_frac(load_frac),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  ptp_tod_accum #(
    .DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) u_accum (
    .clk(clk), .rst(rst), .count_en(count_en), .step(step),
    .load_ns(load_ns), .load_frac(load_frac), .wdata(bus_wdata),
    .ns(cur_ns), .frac(cur_frac)
  );
endmodule

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptp_tod_counter u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // behavioural reference model
  logic [63:0] m_ctrl, m_ns, m_step;
  logic [31:0] m_frac;
  logic [63:0] exp_data;
  logic        exp_valid;

  function automatic logic [63:0] model_read(input logic [11:0] a);
    case (a)
      12'hF00: return m_ctrl;
      12'hF08: return {32'h0, m_frac};
      12'hF10: return m_ns;
      12'hF18: return m_step;
      default: return 64'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl <= '0; m_ns <= '0; m_step <= '0; m_frac <= '0;
      exp_valid <= 1'b0; exp_data <= '0;
    end else begin
      logic [32:0] fs;
      logic [63:0] ns_next;
      exp_valid <= bus_rd;
      exp_data  <= bus_rd ? model_read(bus_addr) : 64'h0;
      fs = {1'b0, m_frac} + {1'b0, m_step[31:0]};
      ns_next = m_ns + {32'h0, m_step[63:32]} + {63'h0, fs[32]};
      if (bus_wr && bus_addr == 12'hF10) begin
        m_ns <= bus_wdata; m_frac <= '0;
      end else if (bus_wr && bus_addr == 12'hF08) begin
        m_frac <= bus_wdata[31:0];
        if (m_ctrl[0]) m_ns <= ns_next;
      end else if (m_ctrl[0]) begin
        m_ns <= ns_next; m_frac <= fs[31:0];
      end
      if (bus_wr && bus_addr == 12'hF00) m_ctrl <= bus_wdata;
      if (bus_wr && bus_addr == 12'hF18) m_step <= bus_wdata;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rd_valid !== exp_valid) begin
        errors++;
        $display("FAIL R10 valid: actual %b expected %b", rd_valid, exp_valid);
      end
      if (exp_valid) begin
        checks++;
        if (rd_data !== exp_data) begin
          errors++;
          $display("FAIL %s data: actual %h expected %h", tag, rd_data, exp_data);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_time();
    rd(12'hF10);
    rd(12'hF08);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic literal_check(input string t, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s literal: actual %h expected %h", t, a, e);
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    tag = "R1";
    rd(12'hF00); literal_check("R1", rd_data, 64'h0);
    rd(12'hF08); literal_check("R1", rd_data, 64'h0);
    rd(12'hF10); literal_check("R1", rd_data, 64'h0);
    rd(12'hF18); literal_check("R1", rd_data, 64'h0);
    // R5: unmapped offsets
    tag = "R5";
    wr(12'hF20, 64'hDEAD_BEEF_0000_0001);
    wr(12'h000, 64'h1);
    rd(12'hF20); literal_check("R5", rd_data, 64'h0);
    rd(12'hF00); rd(12'hF18); read_time();
    // R4 / R3: upper control bits stored, counting stays off
    tag = "R4";
    wr(12'hF18, 64'h1_0000_0000);
    wr(12'hF00, 64'hA5A5_0000_1234_0000);
    rd(12'hF00); literal_check("R4", rd_data, 64'hA5A5_0000_1234_0000);
    tag = "R3";
    idle(5); read_time(); literal_check("R3", rd_data, 64'h0);
    // R2 / R9: enable with 1.0 ns step
    tag = "R2";
    wr(12'hF00, 64'hA5A5_0000_1234_0001);
    idle(10); read_time(); rd(12'hF00);
    // R9: step change mid-count, with immediate read-back of time
    tag = "R9";
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'hF18; bus_wdata = 64'h2_8000_0000;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 12'hF10;
    @(negedge clk);
    bus_rd = 1'b0;
    // R2: half-ns fraction gives a carry every other cycle
    tag = "R2";
    for (int k = 0; k < 6; k++) begin read_time(); idle(k); end
    wr(12'hF18, 64'h0_0000_0001);
    idle(4); read_time();
    // R7: nanosecond load while counting clears fraction
    tag = "R7";
    wr(12'hF18, 64'h1_C000_0000);
    idle(3);
    wr(12'hF10, 64'h0000_1000_0000_0000);
    read_time(); idle(3); read_time();
    // R8: fraction load while counting, with carry from old fraction
    tag = "R8";
    wr(12'hF08, 64'hFFFF_FFFF_FFFF_FFF0);
    read_time(); idle(2); read_time();
    // R3: disable and hold
    tag = "R3";
    wr(12'hF00, 64'h0);
    read_time(); idle(8); read_time();
    wr(12'hF08, 64'h0000_0000_4000_0000);
    read_time();
    // R6: wrap of nanosecond count
    tag = "R6";
    wr(12'hF10, 64'hFFFF_FFFF_FFFF_FFF8);
    wr(12'hF18, 64'h3_0000_0000);
    wr(12'hF00, 64'h1);
    idle(4); read_time(); idle(2); read_time();
    // R10: back-to-back reads
    tag = "R10";
    @(negedge clk); bus_rd = 1'b1; bus_addr = 12'hF10;
    @(negedge clk); bus_addr = 12'hF08;
    @(negedge clk); bus_addr = 12'hF18;
    @(negedge clk); bus_rd = 1'b0;
    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule